// File: doc/BRIEF.md
# Handshake-Loaded Waveform Sample Table

This block holds a table of 32-bit waveform samples that a host fills one word at a time and that a playback engine reads back continuously. The host places a sample on a data register, optionally with a table index and an index-select bit, and then raises a ready flag. The write side notices the flag, commits the word to the table and drops the flag again; the host waits for the flag to drop before offering the next word, so no word is lost or written twice. Words are stored bit for bit, so single-precision values pass through untouched.

Without an explicit index, words land at a sequential write pointer that a load-start pulse returns to entry 0. A load-start pulse also raises a busy interlock that blocks playback until a load-done pulse. Outside a load, the playback engine steps through the first N entries once per enable, where N is a programmable length clamped to the range 64 to 2048, and returns each sample one cycle later with a matching valid strobe.

Top module: `wavetab_top`

## Requirements
- R1: After reset, `host_flag`, `load_busy` and `samp_valid` are all 0, and the write pointer and playback index are 0.
- R2: A one-cycle `host_set` while `host_flag` is 0 makes `host_flag` read 1 after the next rising edge; a `host_set` while `host_flag` is already 1 has no effect (no second write occurs).
- R3: Each rise of `host_flag` causes exactly one table write; `host_flag` stays 1 for exactly two cycles after the edge that set it, then returns to 0.
- R4: With `host_addr_sel` = 0 the word goes to the sequential pointer, which then advances by one; a `load_start` pulse sets the pointer to 0.
- R5: With `host_addr_sel` = 1 the word goes to the entry given by `host_addr` and the sequential pointer is left unchanged.
- R6: All 32 bits of a written word are returned unchanged by playback.
- R7: Each enabled playback cycle reads the entry at the playback index; the index then advances by one, returning to 0 when it is at or beyond length-1.
- R8: A `play_len` below 64 acts as 64 and one above 2048 acts as 2048.
- R9: `samp_valid` is 1 exactly in the cycle after an accepted read and `samp_data` holds that read's entry in the same cycle.
- R10: From the `load_start` edge until the `load_done` edge `load_busy` is 1 and no read is accepted (`samp_valid` stays 0, index frozen); `load_start` returns the playback index to 0 and wins over `load_done`.
- R11: With `play_en` = 0 no read is accepted, `samp_valid` is 0 in the next cycle, and the playback index is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_data | input | 32 | Sample word offered by the host |
| host_addr | input | 11 | Explicit table index |
| host_addr_sel | input | 1 | 1 = use `host_addr`, 0 = use sequential pointer |
| host_set | input | 1 | One-cycle request to raise the ready flag |
| host_flag | output | 1 | Ready flag; cleared by the block after the write |
| load_start | input | 1 | Pulse: begin a load, reset pointer and index, raise busy |
| load_done | input | 1 | Pulse: end a load, release playback |
| load_busy | output | 1 | Playback interlock active |
| play_en | input | 1 | Request one playback read this cycle |
| play_len | input | 12 | Waveform length in samples, clamped to 64..2048 |
| samp_data | output | 32 | Returned sample |
| samp_valid | output | 1 | `samp_data` holds a new sample |

## Verification
The bench loads the whole 2048-entry table sequentially and replays it at lengths 64, 100 and 2048 and at out-of-range lengths 0, 5 and 4000, comparing every returned sample against its own model; a wrong clamp or an off-by-one wrap shows up as a sample from the wrong entry at the seam. It raises the flag a second time while it is still high and then checks that the following word sits at the next entry, which a design writing once per flag-high cycle would push one entry further. An explicit-index write followed by a sequential one catches a pointer that advances on explicit writes, and enables issued during a load catch an interlock that leaks reads or fails to restart playback from entry 0.

// File: rtl/wavetab_pkg.sv
// Package: shared types for the waveform sample table.
// Assumes: included first in compile order.
package wavetab_pkg;

    // Write-side handshake states.
    typedef enum logic [0:0] {
        WR_IDLE  = 1'b0,   // waiting for the ready flag
        WR_CLEAR = 1'b1    // word committed, flag drops on the next edge
    } wr_state_t;

endpackage : wavetab_pkg

// File: rtl/wavetab_loader.sv
// Module: wavetab_loader
// Owns the ready flag and turns each flag rise into exactly one table write,
// either at the sequential pointer or at an explicit index.
// Assumes: host holds data/index/select stable while the flag is high.
module wavetab_loader
    import wavetab_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_set,
    input  logic [DATA_W-1:0] host_data,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_addr_sel,
    input  logic              load_start,
    output logic              flag,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    wr_state_t         state_q;
    logic              flag_q;
    logic [ADDR_W-1:0] ptr_q;

    // Write strobe: flag seen while idle.
    always_comb begin
        wr_en   = (state_q == WR_IDLE) && flag_q;
        wr_addr = host_addr_sel ? host_addr : ptr_q;
        wr_data = host_data;
    end

    assign flag = flag_q;

    // Ready flag: host raises it, write side clears it after commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (state_q == WR_CLEAR) begin
            flag_q <= 1'b0;
        end else if (host_set) begin
            flag_q <= 1'b1;
        end
    end

    // Handshake state: one commit, then one clearing cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
        end else begin
            case (state_q)
                WR_IDLE:  if (flag_q) state_q <= WR_CLEAR;
                default:  state_q <= WR_IDLE;
            endcase
        end
    end

    // Sequential pointer: reset by load start, advances on sequential writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load_start) begin
            ptr_q <= '0;
        end else if (wr_en && !host_addr_sel) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    AST_FLAG_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_set && !flag_q) |=> flag_q); // R2
    AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R3
    AST_FLAG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WR_CLEAR) |=> !flag_q); // R3
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !host_addr_sel && !load_start) |=> (ptr_q == $past(ptr_q) + 1'b1)); // R4
    AST_EXPL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && host_addr_sel && !load_start) |=> $stable(ptr_q)); // R5

endmodule : wavetab_loader

// File: rtl/wavetab_mem.sv
// Module: wavetab_mem
// Single-write, single-read sample storage with a registered read port.
// Assumes: DEPTH equals 2**ADDR_W; contents are not reset.
module wavetab_mem #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 2048,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // Store a word when the write side commits.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    // Registered read: data appears one cycle after the request.
    always_ff @(posedge clk) begin
        if (rd_en) rd_q <= mem_q[rd_addr];
    end

    assign rd_data = rd_q;

endmodule : wavetab_mem

// File: rtl/wavetab_player.sv
// Module: wavetab_player
// Steps a read index over the clamped waveform length and holds the load
// interlock that blocks reads while the table is being reloaded.
// Assumes: load_start and load_done are single-cycle pulses.
module wavetab_player #(
    parameter int DEPTH   = 2048,
    parameter int MIN_LEN = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              play_en,
    input  logic [LEN_W-1:0]  play_len,
    input  logic              load_start,
    input  logic              load_done,
    output logic              busy,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              samp_valid
);

    localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(DEPTH);

    logic              busy_q;
    logic              valid_q;
    logic [ADDR_W-1:0] idx_q;
    logic [LEN_W-1:0]  len_eff;
    logic              at_end;

    // Clamp the requested length into the supported range.
    always_comb begin
        if (play_len < LEN_LO)      len_eff = LEN_LO;
        else if (play_len > LEN_HI) len_eff = LEN_HI;
        else                        len_eff = play_len;
    end

    // Read acceptance and wrap detection.
    always_comb begin
        rd_en  = play_en && !busy_q && !load_start;
        at_end = ({1'b0, idx_q} >= (len_eff - 1'b1));
    end

    assign busy       = busy_q;
    assign rd_addr    = idx_q;
    assign samp_valid = valid_q;

    // Interlock: set by load start, cleared by load done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (load_start) begin
            busy_q <= 1'b1;
        end else if (load_done) begin
            busy_q <= 1'b0;
        end
    end

    // Playback index: restart on load, advance and wrap on each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (load_start) begin
            idx_q <= '0;
        end else if (rd_en) begin
            idx_q <= at_end ? '0 : idx_q + 1'b1;
        end
    end

    // Valid strobe lines up with the registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= rd_en;
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && at_end) |=> (idx_q == '0)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!play_en && !load_start) |=> $stable(idx_q)); // R11

endmodule : wavetab_player

// File: rtl/wavetab_top.sv
// Module: wavetab_top
// Waveform sample table loaded through a flag handshake and replayed over a
// programmable length, with a load interlock between the two sides.
// Assumes: host follows the flag protocol; default depth 2048, length 64..2048.
module wavetab_top #(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 2048,
    parameter int MIN_LEN = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] host_data,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_addr_sel,
    input  logic              host_set,
    output logic              host_flag,
    input  logic              load_start,
    input  logic              load_done,
    output logic              load_busy,
    input  logic              play_en,
    input  logic [LEN_W-1:0]  play_len,
    output logic [DATA_W-1:0] samp_data,
    output logic              samp_valid
);

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              rd_en;
    logic [ADDR_W-1:0] rd_addr;

    wavetab_loader #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) loader_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_set     (host_set),
        .host_data    (host_data),
        .host_addr    (host_addr),
        .host_addr_sel(host_addr_sel),
        .load_start   (load_start),
        .flag         (host_flag),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data)
    );

    wavetab_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) mem_i (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .rd_data(samp_data)
    );

    wavetab_player #(.DEPTH(DEPTH), .MIN_LEN(MIN_LEN)) player_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .play_en   (play_en),
        .play_len  (play_len),
        .load_start(load_start),
        .load_done (load_done),
        .busy      (load_busy),
        .rd_en     (rd_en),
        .rd_addr   (rd_addr),
        .samp_valid(samp_valid)
    );

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        load_busy |=> !samp_valid); // R10
    AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        samp_valid |-> $past(play_en)); // R9
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        load_start |=> load_busy); // R10

endmodule : wavetab_top

// File: tb/wavetab_top_tb_top.sv
// Bench: loads the full table, replays it over many lengths and checks every
// returned sample against a model array computed in the bench.
module wavetab_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2048;
    localparam int MIN_LEN    = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] host_data = '0;
    logic [10:0] host_addr = '0;
    logic        host_addr_sel = 1'b0;
    logic        host_set = 1'b0;
    logic        host_flag;
    logic        load_start = 1'b0;
    logic        load_done = 1'b0;
    logic        load_busy;
    logic        play_en = 1'b0;
    logic [11:0] play_len = 12'd64;
    logic [31:0] samp_data;
    logic        samp_valid;

    int          n_checks = 0;
    int          n_errors = 0;
    int          exp_idx  = 0;
    logic [31:0] ref_mem [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    wavetab_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_data(host_data), .host_addr(host_addr),
        .host_addr_sel(host_addr_sel), .host_set(host_set),
        .host_flag(host_flag), .load_start(load_start),
        .load_done(load_done), .load_busy(load_busy),
        .play_en(play_en), .play_len(play_len),
        .samp_data(samp_data), .samp_valid(samp_valid)
    );

    function automatic logic [31:0] pattern(input int i);
        return (32'(i) * 32'h9E37_79B9) ^ 32'h4049_0FDB;
    endfunction

    function automatic int eff_len(input int len);
        if (len < MIN_LEN) return MIN_LEN;
        if (len > DEPTH)   return DEPTH;
        return len;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    // One host word; dbl raises the flag again while it is still high.
    task automatic host_write(input logic [31:0] d, input logic [10:0] a,
                              input bit sel, input bit dbl, input bit chk);
        while (host_flag) @(negedge clk);
        host_data = d; host_addr = a; host_addr_sel = sel; host_set = 1'b1;
        @(negedge clk);
        host_set = dbl;
        if (chk) check(host_flag == 1'b1, "R2 flag raised", 32'(host_flag), 32'd1);
        @(negedge clk);
        host_set = 1'b0;
        if (chk) check(host_flag == 1'b1, "R3 flag held second cycle", 32'(host_flag), 32'd1);
        @(negedge clk);
        if (chk) check(host_flag == 1'b0, "R3 flag cleared", 32'(host_flag), 32'd0);
        while (host_flag) @(negedge clk);
    endtask

    task automatic pulse_start();
        load_start = 1'b1; @(negedge clk); load_start = 1'b0;
        exp_idx = 0;
        check(load_busy == 1'b1, "R10 busy after start", 32'(load_busy), 32'd1);
    endtask

    task automatic pulse_done();
        load_done = 1'b1; @(negedge clk); load_done = 1'b0;
        check(load_busy == 1'b0, "R10 busy released", 32'(load_busy), 32'd0);
    endtask

    // n enabled cycles at the given length, each returned sample compared.
    task automatic play_run(input int len, input int n, input string req);
        int e;
        e = eff_len(len);
        play_len = 12'(len);
        play_en  = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(samp_valid == 1'b1, {req, " R9 valid"}, 32'(samp_valid), 32'd1);
            check(samp_data == ref_mem[exp_idx], {req, " R6 sample"}, samp_data,
                  ref_mem[exp_idx]);
            exp_idx = (exp_idx >= e - 1) ? 0 : exp_idx + 1;
            if (k == n - 1) play_en = 1'b0;
        end
        @(negedge clk);
        check(samp_valid == 1'b0, "R11 valid drops", 32'(samp_valid), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(host_flag == 1'b0, "R1 flag", 32'(host_flag), 32'd0);
        check(load_busy == 1'b0, "R1 busy", 32'(load_busy), 32'd0);
        check(samp_valid == 1'b0, "R1 valid", 32'(samp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: full sequential load.
        pulse_start();
        for (int i = 0; i < DEPTH; i++) begin
            ref_mem[i] = pattern(i);
            host_write(pattern(i), 11'h7FF, 1'b0, 1'b0, i == 0);
        end
        pulse_done();

        // R7 / R8: replay over several lengths.
        play_run(64, 140, "R7 len64");
        // R11: gap with enable low keeps the index.
        repeat (3) begin
            @(negedge clk);
            check(samp_valid == 1'b0, "R11 idle", 32'(samp_valid), 32'd0);
        end
        play_run(100, 230, "R7 len100");
        play_run(0, 70, "R8 len0");
        play_run(5, 70, "R8 len5");
        play_run(2048, 2060, "R7 len2048");
        play_run(4000, 2060, "R8 len4000");

        // R10: reload with reads blocked; R5 explicit index; R2 double set.
        pulse_start();
        play_en = 1'b1;
        repeat (6) begin
            @(negedge clk);
            check(samp_valid == 1'b0, "R10 no read while busy", 32'(samp_valid), 32'd0);
        end
        play_en = 1'b0;
        host_write(32'hDEAD_BEEF, 11'd7, 1'b1, 1'b0, 1'b1);
        ref_mem[7] = 32'hDEAD_BEEF;
        host_write(32'h3F80_0000, 11'd500, 1'b0, 1'b1, 1'b0);
        ref_mem[0] = 32'h3F80_0000;
        host_write(32'hBF80_0001, 11'd500, 1'b0, 1'b0, 1'b0);
        ref_mem[1] = 32'hBF80_0001;
        host_write(32'h8000_0000, 11'd2047, 1'b1, 1'b0, 1'b0);
        ref_mem[2047] = 32'h8000_0000;
        host_write(32'h7F80_0000, 11'd9, 1'b0, 1'b0, 1'b0);
        ref_mem[2] = 32'h7F80_0000;
        pulse_done();
        play_run(64, 70, "R5 R2 reload");
        play_run(2048, 2049, "R5 top entry");

        finish_run();
    end

endmodule : wavetab_top_tb_top